// File: doc/BRIEF.md
# Acquisition Window Selector and Picture Reducer

This block takes one channel of sampled video, cuts a fixed-size active region out of each incoming field and shrinks that region by independent horizontal and vertical integer factors. The result is written to a field memory as a stream of reduced pixels, each carrying its column and row address. A chip with two picture sources uses two identical instances, one per channel.

Position inside the field is tracked by two counters. A horizontal counter counts accepted pixel strobes since the last line sync. A vertical counter counts line syncs since the last field sync. The region starts at a built-in base position plus a programmable offset on each axis. It is a fixed number of pixels wide. Its height depends on the selected television standard. Horizontally, each group of N adjacent pixels collapses into one output pixel, their truncated mean. Vertically, only every N-th line of the region is written. The mode inputs (standard, both factors, both offsets) are captured at each field sync, so a change made in mid-field first shows in the following field.

Top module: `pip_acq_reducer`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `vsync` pulse, `wr_en` stays low whatever pixels and line syncs arrive.
- R2: A cycle with `pix_vld` high and both syncs low is a strobe. The strobes after an `hsync` are numbered 0, 1, 2 and so on. A strobe lies in the horizontal window when its number is at least `H_BASE + h_off` and below `H_BASE + h_off + ACT_PIX`.
- R3: The line that begins with the k-th `hsync` after a `vsync` has line number k. A line lies in the vertical window when k is at least `V_BASE + v_off` and below that value plus `LINES_NTSC` (when `std_pal` = 0) or `LINES_PAL` (when `std_pal` = 1).
- R4: The code on `h_fact` selects factor code+1 (0→1, 1→2, 2→3, 3→4). Each output pixel is floor(sum/N) of N consecutive in-window pixels, and each written line holds ACT_PIX/N pixels.
- R5: The code on `v_fact` selects factor code+1 in the same way. Of the window lines, those with a window-relative index of 0, N, 2N and so on are written, which gives LINES/N written lines per field.
- R6: `wr_col` is 0 for the first write of each line and rises by one per write. `wr_row` is 0 for the first written line of a field and rises by one per written line.
- R7: Standard, factors and offsets are sampled only in a `vsync` cycle. Changes at other times do not affect the current field.
- R8: `wr_en` is high for exactly the one cycle after the strobe that completes a group. Pixels in a sync cycle and cycles with `pix_vld` low neither count nor contribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Pixel sample valid |
| pix_in | input | PIX_W | Pixel sample |
| hsync | input | 1 | Line sync pulse, one cycle |
| vsync | input | 1 | Field sync pulse, one cycle |
| std_pal | input | 1 | 0 selects the short field, 1 the long field |
| h_fact | input | 2 | Horizontal factor code (factor = code+1) |
| v_fact | input | 2 | Vertical factor code (factor = code+1) |
| h_off | input | OFF_W | Horizontal fine offset in pixels |
| v_off | input | OFF_W | Vertical fine offset in lines |
| wr_en | output | 1 | Write strobe to field memory |
| wr_data | output | PIX_W | Reduced pixel |
| wr_col | output | COL_W | Column address |
| wr_row | output | ROW_W | Row address |

## Verification
A wrong count in the horizontal counter or its start compare moves the averaged groups by whole pixels. It shows as wrong `wr_data` on the very first write of every written line. A fault in the line phase or row counter shows within one field as a wrong number of written lines or a wrong `wr_row` sequence. A group phase that gets out of step shows at once as misplaced `wr_en` cycles and wrong totals. Every field is therefore compared write by write, checking the exact cycle as well as the data and both addresses.

// File: rtl/pip_acq_pkg.sv
`timescale 1ns/1ps
package pip_acq_pkg;

  typedef struct packed {
    logic       pal;
    logic [1:0] hcode;
    logic [1:0] vcode;
  } acq_mode_t;

  function automatic logic [2:0] code_to_factor(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

endpackage

// File: rtl/pip_acq_timing.sv
`timescale 1ns/1ps
module pip_acq_timing
  import pip_acq_pkg::*;
#(
  parameter int ACT_PIX    = 672,
  parameter int LINES_NTSC = 228,
  parameter int LINES_PAL  = 276,
  parameter int H_BASE     = 120,
  parameter int V_BASE     = 20,
  parameter int OFF_W      = 6,
  parameter int ROW_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             pix_vld,
  input  acq_mode_t        mode_in,
  input  logic [OFF_W-1:0] h_off,
  input  logic [OFF_W-1:0] v_off,
  output logic [1:0]       hcode,
  output logic             take,
  output logic [ROW_W-1:0] row_cur
);

  localparam int LINES_MAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC;
  localparam int HC_W = $clog2(H_BASE + (1 << OFF_W) + ACT_PIX + 2);
  localparam int VC_W = $clog2(V_BASE + (1 << OFF_W) + LINES_MAX + 2);
  localparam logic [HC_W-1:0] HC_MAX = '1;
  localparam logic [VC_W-1:0] VC_MAX = '1;

  // field-sampled mode
  acq_mode_t        mode_q, mode_d;
  logic [OFF_W-1:0] hoff_q, hoff_d, voff_q, voff_d;

  // position counters
  logic [HC_W-1:0]  hcnt_q, hcnt_d;
  logic [VC_W-1:0]  vcnt_q, vcnt_d, vcnt_inc;
  logic [1:0]       vph_q, vph_d;
  logic [ROW_W-1:0] row_q, row_d;

  logic             strobe, h_in, v_in, keep;
  logic [HC_W-1:0]  h_lo, h_hi;
  logic [VC_W-1:0]  v_lo, v_hi, n_lines;

  assign strobe   = pix_vld & ~hsync & ~vsync;
  assign h_lo     = HC_W'(H_BASE) + HC_W'(hoff_q);
  assign h_hi     = h_lo + HC_W'(ACT_PIX);
  assign n_lines  = mode_q.pal ? VC_W'(LINES_PAL) : VC_W'(LINES_NTSC);
  assign v_lo     = VC_W'(V_BASE) + VC_W'(voff_q);
  assign v_hi     = v_lo + n_lines;
  assign h_in     = (hcnt_q >= h_lo) && (hcnt_q < h_hi);
  assign v_in     = (vcnt_q >= v_lo) && (vcnt_q < v_hi);
  assign keep     = v_in && (vph_q == 2'd0);
  assign vcnt_inc = vcnt_q + VC_W'(1);

  always_comb begin
    mode_d = mode_q;
    hoff_d = hoff_q;
    voff_d = voff_q;
    hcnt_d = hcnt_q;
    vcnt_d = vcnt_q;
    vph_d  = vph_q;
    row_d  = row_q;
    if (vsync) begin
      mode_d = mode_in;
      hoff_d = h_off;
      voff_d = v_off;
      hcnt_d = '0;
      vcnt_d = '0;
      vph_d  = 2'd0;
      row_d  = '0;
    end else if (hsync) begin
      hcnt_d = '0;
      if (vcnt_q != VC_MAX) vcnt_d = vcnt_inc;
      if (vcnt_inc == v_lo)            vph_d = 2'd0;
      else if (vph_q == mode_q.vcode)  vph_d = 2'd0;
      else                             vph_d = vph_q + 2'd1;
      if (keep) row_d = row_q + ROW_W'(1);
    end else if (strobe && (hcnt_q != HC_MAX)) begin
      hcnt_d = hcnt_q + HC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      hoff_q <= '0;
      voff_q <= '0;
      hcnt_q <= HC_MAX;
      vcnt_q <= VC_MAX;
      vph_q  <= 2'd0;
      row_q  <= '0;
    end else begin
      mode_q <= mode_d;
      hoff_q <= hoff_d;
      voff_q <= voff_d;
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
      vph_q  <= vph_d;
      row_q  <= row_d;
    end
  end

  assign take    = strobe && h_in && keep;
  assign hcode   = mode_q.hcode;
  assign row_cur = row_q;

  // checker: pixels accepted within one line never exceed the window width
  logic [HC_W-1:0] tk_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tk_cnt_q <= '0;
    else if (hsync || vsync) tk_cnt_q <= '0;
    else if (take)           tk_cnt_q <= tk_cnt_q + HC_W'(1);
  end

  a_r2_take_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (int'(tk_cnt_q) < ACT_PIX));

  a_r5_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (int'(row_q) < int'(n_lines) / int'(code_to_factor(mode_q.vcode))));

endmodule

// File: rtl/pip_acq_hred.sv
`timescale 1ns/1ps
module pip_acq_hred
  import pip_acq_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int ACT_PIX = 672,
  parameter int COL_W   = 10,
  parameter int ROW_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic [PIX_W-1:0] pix,
  input  logic [1:0]       hcode,
  input  logic [ROW_W-1:0] row_in,
  output logic             wr_en,
  output logic [PIX_W-1:0] wr_data,
  output logic [COL_W-1:0] wr_col,
  output logic [ROW_W-1:0] wr_row
);

  localparam int ACC_W = PIX_W + 2;

  logic [1:0]       ph_q, ph_d;
  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic [COL_W-1:0] col_q, col_d;
  logic [PIX_W-1:0] avg;
  logic             last, emit;

  assign sum  = acc_q + ACC_W'(pix);
  assign last = (ph_q == hcode);
  assign emit = take && last;

  always_comb begin
    unique case (hcode)
      2'd0:    avg = PIX_W'(sum);
      2'd1:    avg = PIX_W'(sum >> 1);
      2'd2:    avg = PIX_W'(sum / ACC_W'(3));
      default: avg = PIX_W'(sum >> 2);
    endcase
  end

  always_comb begin
    ph_d  = ph_q;
    acc_d = acc_q;
    col_d = col_q;
    if (clr) begin
      ph_d  = 2'd0;
      acc_d = '0;
      col_d = '0;
    end else if (take) begin
      if (last) begin
        ph_d  = 2'd0;
        acc_d = '0;
        col_d = col_q + COL_W'(1);
      end else begin
        ph_d  = ph_q + 2'd1;
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 2'd0;
      acc_q <= '0;
      col_q <= '0;
      wr_en <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      acc_q <= acc_d;
      col_q <= col_d;
      wr_en <= emit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_data <= '0;
      wr_col  <= '0;
      wr_row  <= '0;
    end else if (emit) begin
      wr_data <= avg;
      wr_col  <= col_q;
      wr_row  <= row_in;
    end
  end

  a_r6_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_row == $past(wr_row)));

  a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_col) < ACT_PIX / int'(code_to_factor(hcode))));

  a_r8_quiet_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wr_en);

endmodule

// File: rtl/pip_acq_reducer.sv
`timescale 1ns/1ps
module pip_acq_reducer
  import pip_acq_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int ACT_PIX    = 672,
  parameter int LINES_NTSC = 228,
  parameter int LINES_PAL  = 276,
  parameter int H_BASE     = 120,
  parameter int V_BASE     = 20,
  parameter int OFF_W      = 6,
  localparam int LINES_MAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int COL_W     = $clog2(ACT_PIX + 1),
  localparam int ROW_W     = $clog2(LINES_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             std_pal,
  input  logic [1:0]       h_fact,
  input  logic [1:0]       v_fact,
  input  logic [OFF_W-1:0] h_off,
  input  logic [OFF_W-1:0] v_off,
  output logic             wr_en,
  output logic [PIX_W-1:0] wr_data,
  output logic [COL_W-1:0] wr_col,
  output logic [ROW_W-1:0] wr_row
);

  acq_mode_t        mode_in;
  logic [1:0]       hcode;
  logic             take;
  logic [ROW_W-1:0] row_cur;

  assign mode_in = '{pal: std_pal, hcode: h_fact, vcode: v_fact};

  pip_acq_timing #(
    .ACT_PIX(ACT_PIX), .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL),
    .H_BASE(H_BASE), .V_BASE(V_BASE), .OFF_W(OFF_W), .ROW_W(ROW_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .pix_vld(pix_vld),
    .mode_in(mode_in), .h_off(h_off), .v_off(v_off),
    .hcode(hcode), .take(take), .row_cur(row_cur)
  );

  pip_acq_hred #(
    .PIX_W(PIX_W), .ACT_PIX(ACT_PIX), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_hred (
    .clk(clk), .rst_n(rst_n), .clr(hsync | vsync), .take(take), .pix(pix_in),
    .hcode(hcode), .row_in(row_cur),
    .wr_en(wr_en), .wr_data(wr_data), .wr_col(wr_col), .wr_row(wr_row)
  );

endmodule

// File: tb/sim_pip_acq_reducer.sv
`timescale 1ns/1ps
module sim_pip_acq_reducer;

  localparam int PIX_W = 8, ACT = 24, LN = 12, LP = 24, HB = 3, VB = 2, OW = 3;
  localparam int NP = HB + 7 + ACT + 2;   // strobes per line
  localparam int NL = VB + 7 + LP + 1;    // lines per field

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_vld = 1'b0, hsync = 1'b0, vsync = 1'b0, std_pal = 1'b0;
  logic [PIX_W-1:0] pix_in = '0;
  logic [1:0] h_fact = '0, v_fact = '0;
  logic [OW-1:0] h_off = '0, v_off = '0;
  logic wr_en;
  logic [PIX_W-1:0] wr_data;
  logic [4:0] wr_col, wr_row;

  pip_acq_reducer #(.PIX_W(PIX_W), .ACT_PIX(ACT), .LINES_NTSC(LN), .LINES_PAL(LP),
    .H_BASE(HB), .V_BASE(VB), .OFF_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_in), .hsync(hsync),
    .vsync(vsync), .std_pal(std_pal), .h_fact(h_fact), .v_fact(v_fact),
    .h_off(h_off), .v_off(v_off), .wr_en(wr_en), .wr_data(wr_data),
    .wr_col(wr_col), .wr_row(wr_row));

  always #2 clk = ~clk;

  typedef struct { int d; int x; int y; int cyc; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0, n_wr = 0, f_err = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      report();
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // write monitor: compares each write with the bench model queue
  always @(negedge clk) if (rst_n) begin
    while (q.size() > 0 && q[0].cyc < cyc) begin
      f_err++; n_chk++; n_fail++;
      $display("FAIL R8 missing write: actual none expected cycle %0d", q[0].cyc);
      void'(q.pop_front());
    end
    if (wr_en) begin
      n_wr++;
      if (q.size() == 0 || q[0].cyc != cyc) begin
        f_err++; n_chk++; n_fail++;
        $display("FAIL R1/R8 unexpected write: actual cycle %0d expected %0d", cyc,
                 q.size() ? q[0].cyc : -1);
      end else begin
        if (wr_data != q[0].d) begin
          f_err++; n_chk++; n_fail++;
          $display("FAIL R4 data: actual %0d expected %0d", wr_data, q[0].d);
        end
        if (wr_col != q[0].x || wr_row != q[0].y) begin
          f_err++; n_chk++; n_fail++;
          $display("FAIL R6 addr: actual %0d/%0d expected %0d/%0d", wr_col, wr_row, q[0].x, q[0].y);
        end
        void'(q.pop_front());
      end
    end
  end

  function automatic int pv(int k, int i);
    return (k * 37 + i * 11 + 5) & 255;
  endfunction

  // one field; the model uses the mode given, optionally changing the pins after vsync
  task automatic run_field(input int pal, hc, vc, ho, vo, bit gap, bit chg, input string tag);
    int lines, hf, vf, hs, vs, sum, nexp, w0;
    lines = pal ? LP : LN; hf = hc + 1; vf = vc + 1; hs = HB + ho; vs = VB + vo;
    nexp = (lines / vf) * (ACT / hf);
    f_err = 0; w0 = n_wr; sum = 0;
    std_pal = pal[0]; h_fact = hc[1:0]; v_fact = vc[1:0];
    h_off = ho[OW-1:0]; v_off = vo[OW-1:0];
    vsync = 1'b1; pix_vld = 1'b1; pix_in = 8'h5A;
    @(negedge clk);
    vsync = 1'b0;
    if (chg) begin
      std_pal = ~std_pal; h_fact = ~h_fact; v_fact = ~v_fact;
      h_off = h_off ^ 3'd5; v_off = v_off ^ 3'd5;
    end
    for (int k = 1; k <= NL; k++) begin
      hsync = 1'b1; pix_vld = 1'b1; pix_in = 8'hFF;
      @(negedge clk);
      hsync = 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (gap && (i % 3 == 1)) begin
          pix_vld = 1'b0; pix_in = 8'h11;
          @(negedge clk);
        end
        pix_vld = 1'b1; pix_in = pv(k, i)[PIX_W-1:0];
        if (k >= vs && k < vs + lines && i >= hs && i < hs + ACT) begin
          int rx = i - hs;
          if (rx % hf == 0) sum = 0;
          sum += pv(k, i);
          if (rx % hf == hf - 1 && (k - vs) % vf == 0)
            q.push_back('{d: sum / hf, x: rx / hf, y: (k - vs) / vf, cyc: cyc + 1});
        end
        @(negedge clk);
      end
    end
    pix_vld = 1'b0;
    repeat (4) @(negedge clk);
    check(n_wr - w0 == nexp, {tag, " write count"}, n_wr - w0, nexp);
    check(f_err == 0 && q.size() == 0, {tag, " field content"}, f_err, 0);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check(wr_en == 1'b0, "R1 reset", wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_no_field();
    int w0 = n_wr;
    for (int k = 0; k < 3; k++) begin
      hsync = 1'b1; @(negedge clk); hsync = 1'b0;
      for (int i = 0; i < NP; i++) begin
        pix_vld = 1'b1; pix_in = pv(k, i)[PIX_W-1:0]; @(negedge clk);
      end
    end
    pix_vld = 1'b0; repeat (3) @(negedge clk);
    check(n_wr == w0, "R1 no writes before vsync", n_wr - w0, 0);
  endtask

  initial begin
    t_reset();
    t_no_field();
    run_field(0, 0, 0, 0, 0, 1'b0, 1'b0, "R2 R3 R4 R6 full size");
    run_field(1, 2, 1, 5, 3, 1'b0, 1'b0, "R2 R3 R5 h3 v2 long field");
    run_field(0, 3, 3, 7, 7, 1'b0, 1'b0, "R4 R5 h4 v4 max offset");
    run_field(1, 1, 2, 2, 1, 1'b1, 1'b0, "R8 R5 h2 v3 with gaps");
    run_field(0, 1, 0, 1, 2, 1'b0, 1'b1, "R7 mode held mid-field");
    run_field(1, 2, 3, 4, 7, 1'b0, 1'b0, "R7 next field takes new mode");
    report();
  end

endmodule